// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block produces the drive-level sequence for every common and segment pin of a segment LCD panel run at either three or four time-multiplexed commons. It does not make voltages. Each pin gets a 2-bit code naming one of four rails, and analog circuitry outside the block turns that code into a voltage. The inputs are a display bit array that has already been latched, a handful of configuration bits and the oscillator clock. Duty, bias, blanking, power saving and the number of static output ports may all change while the block runs.

One frame lasts 384 oscillator clocks. The frame splits into two half-frames of opposite polarity, so every pixel sees zero average voltage. Each half-frame then splits into equal time slots, one per common. One pin is shared: at four-common operation it carries the fourth common, and at three-common operation it is segment 40. The first four segment pins can instead carry static output-port bits taken from the display array.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: While reset is asserted, every common, shared-pin and segment code is 00 (VSS) and every port bit is 0.
- R2: A frame is 384 clocks long, made of two 192-clock half-frames (the first positive, the second negative). Each half-frame holds one slot per common: 64 clocks at three commons, 48 clocks at four. Common k is selected in slot k-1. The outputs lag the frame position by one clock.
- R3: Level codes are 00 VSS, 01 V2, 10 V1 and 11 V0. A selected common drives V0 in the positive half and VSS in the negative half. An unselected common drives V2 (third bias) or V1 (half bias) in the positive half, and V1 in the negative half.
- R4: An on segment drives VSS in the positive half and V0 in the negative half. An off segment drives V1 in the positive half, and V2 (third bias) or V1 (half bias) in the negative half. A display bit of 1 means on.
- R5: At three commons, the shared pin acts as SEG40. Physical segment n in slot k uses display bit D(3(n-1)+k), where D1 is bit 0 of disp_i. seg_lvl_o lane j (0-based) carries SEG(j+1) for j<39, and SEG(j+2) for j of 39 or more.
- R6: At four commons, the shared pin carries COM4. Segment lane j uses bit D(4j+k) in slot k.
- R7: With blanking on, every segment drives its off level while the commons keep their normal sequence.
- R8: With a non-zero power-save code, every common, shared-pin and segment code is VSS. The port bits keep working.
- R9: Port-select code 00 gives no ports, 01 gives two, 10 gives three and 11 gives four. Lane i (i<4) that is a port drives VSS on seg_lvl_o, and port_o[i] equals bit D(3i+1) at three commons or D(4i+1) at four. Port bits that are not selected are 0.
- R10: At half bias, no output ever uses the V2 code: every unselected level is V1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| duty4_i | input | 1 | 1 selects four commons, 0 selects three |
| bias_half_i | input | 1 | 1 selects half bias, 0 selects third bias |
| blank_i | input | 1 | 1 forces every segment to its off level |
| psave_i | input | 2 | Power-save code; any non-zero value quiets the panel |
| port_sel_i | input | 2 | Number of static ports on the first four lanes |
| disp_i | input | 164 | Display bits, D1 at bit 0 |
| com_lvl_o | output | 6 | Level codes of COM1..COM3, 2 bits each, COM1 lowest |
| shared_lvl_o | output | 2 | Level code of the COM4/SEG40 pin |
| seg_lvl_o | output | 82 | Level codes of the 41 segment lanes, lane 0 lowest |
| port_o | output | 4 | Static port bits P0..P3 |

## Verification
Three kinds of fault in the slot or half-frame counters show up at the ports. A wrong slot length moves the V0 pulse of the commons away from multiples of 48 or 64 clocks, and that is visible within the first slot boundary. A missed polarity flip leaves the commons at V0 where VSS is due once clock 192 passes. A wrong index into the display array makes the segment code of the affected lane disagree with the pattern in the very slot that reads it. Stuck blanking, power-save or port gating shows up at the next output register update, one clock after the control input changes.

// File: rtl/lcd_wave_pkg.sv
package lcd_wave_pkg;

   typedef enum logic [1:0] {
      LV_VSS = 2'b00,
      LV_V2  = 2'b01,
      LV_V1  = 2'b10,
      LV_V0  = 2'b11
   } lvl_e;

   // Common rail for one slot: sel = this common owns the slot, neg = second half-frame
   function automatic lvl_e com_level(input logic sel, input logic neg, input logic bias_half);
      if (neg)      return sel ? LV_VSS : LV_V1;
      else if (sel) return LV_V0;
      else          return bias_half ? LV_V1 : LV_V2;
   endfunction

   // Segment rail: on pixels sit opposite the selected common
   function automatic lvl_e seg_level(input logic on, input logic neg, input logic bias_half);
      if (!neg)    return on ? LV_VSS : LV_V1;
      else if (on) return LV_V0;
      else         return bias_half ? LV_V1 : LV_V2;
   endfunction

endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
   parameter int FRAME_CLKS = 384
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       duty4_i,
   output logic       half_o,
   output logic [1:0] slot_o
);
   localparam int HALF_CLKS = FRAME_CLKS / 2;
   localparam int SLOT3     = HALF_CLKS / 3;
   localparam int SLOT4     = HALF_CLKS / 4;
   localparam int TW        = $clog2(SLOT3);

   if ((FRAME_CLKS % 24) != 0 || FRAME_CLKS < 24) begin : g_bad_frame
      $error("FRAME_CLKS must be a positive multiple of 24");
   end

   logic [TW-1:0] tick_q;
   logic [1:0]    slot_q;
   logic          half_q;
   logic [TW-1:0] slot_last;
   logic [1:0]    final_slot;

   assign slot_last  = duty4_i ? TW'(SLOT4 - 1) : TW'(SLOT3 - 1);
   assign final_slot = duty4_i ? 2'd3 : 2'd2;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tick_q <= '0;
         slot_q <= '0;
         half_q <= 1'b0;
      end else if (tick_q >= slot_last) begin
         tick_q <= '0;
         if (slot_q >= final_slot) begin
            slot_q <= '0;
            half_q <= ~half_q;
         end else begin
            slot_q <= slot_q + 2'd1;
         end
      end else begin
         tick_q <= tick_q + TW'(1);
      end
   end

   assign half_o = half_q;
   assign slot_o = slot_q;

   AST_HALF_AT_SLOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (half_q != $past(half_q)) |-> (slot_q == 2'd0 && tick_q == '0)); // R2

endmodule

// File: rtl/lcd_com_bank.sv
module lcd_com_bank
   import lcd_wave_pkg::*;
#(
   parameter int NUM_COMS = 4
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  half_i,
   input  logic [1:0]            slot_i,
   input  logic                  bias_half_i,
   input  logic                  psave_i,
   output logic [2*NUM_COMS-1:0] com_lvl_o
);
   if (NUM_COMS < 3 || NUM_COMS > 4) begin : g_bad_coms
      $error("NUM_COMS must be 3 or 4");
   end

   logic [NUM_COMS-1:0] top_rail;

   for (genvar k = 0; k < NUM_COMS; k++) begin : g_com
      logic [1:0] lvl_q;
      lvl_e       nxt;
      assign nxt = psave_i ? LV_VSS : com_level(slot_i == 2'(k), half_i, bias_half_i);
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) lvl_q <= LV_VSS;
         else         lvl_q <= nxt;
      end
      assign com_lvl_o[2*k +: 2] = lvl_q;
      assign top_rail[k]         = (lvl_q == LV_V0);
   end

   AST_ONE_COM_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(top_rail)); // R3

   AST_COM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      psave_i |=> (com_lvl_o == '0)); // R8

endmodule

// File: rtl/lcd_seg_lane.sv
module lcd_seg_lane
   import lcd_wave_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       half_i,
   input  logic [1:0] slot_i,
   input  logic       bias_half_i,
   input  logic       blank_i,
   input  logic       psave_i,
   input  logic       port_mode_i,
   input  logic [3:0] bits_i,
   output logic [1:0] lvl_o
);
   logic [1:0] lvl_q;
   logic       on;
   lvl_e       nxt;

   assign on  = bits_i[slot_i] & ~blank_i;
   assign nxt = (psave_i || port_mode_i) ? LV_VSS : seg_level(on, half_i, bias_half_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= LV_VSS;
      else         lvl_q <= nxt;
   end

   assign lvl_o = lvl_q;

   AST_BLANK_OFF_RAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blank_i && !psave_i && !port_mode_i) |=> (lvl_q == LV_V1 || lvl_q == LV_V2)); // R7

   AST_LANE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      psave_i |=> (lvl_q == LV_VSS)); // R8

endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
   import lcd_wave_pkg::*;
#(
   parameter int NUM_LANES  = 41,
   parameter int SKIP_AFTER = 39,
   parameter int NUM_PORTS  = 4,
   parameter int FRAME_CLKS = 384
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   duty4_i,
   input  logic                   bias_half_i,
   input  logic                   blank_i,
   input  logic [1:0]             psave_i,
   input  logic [1:0]             port_sel_i,
   input  logic [4*NUM_LANES-1:0] disp_i,
   output logic [5:0]             com_lvl_o,
   output logic [1:0]             shared_lvl_o,
   output logic [2*NUM_LANES-1:0] seg_lvl_o,
   output logic [NUM_PORTS-1:0]   port_o
);
   localparam int DATA_BITS = 4 * NUM_LANES;
   localparam int PW        = $clog2(NUM_PORTS + 1);

   if (NUM_PORTS < 2 || NUM_PORTS > 4 || NUM_PORTS > NUM_LANES) begin : g_bad_ports
      $error("NUM_PORTS must lie in 2..4");
   end
   if (SKIP_AFTER >= NUM_LANES || 3 * NUM_LANES + 3 > DATA_BITS) begin : g_bad_lanes
      $error("SKIP_AFTER must lie below NUM_LANES");
   end

   logic          half;
   logic [1:0]    slot;
   logic          quiet;
   logic [7:0]    com_all;
   logic [1:0]    seg40_lvl;
   logic [PW-1:0] port_cnt;

   assign quiet    = (psave_i != 2'b00);
   assign port_cnt = (port_sel_i == 2'b00) ? '0 : PW'(port_sel_i) + PW'(1);

   lcd_frame_timer #(.FRAME_CLKS(FRAME_CLKS)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .duty4_i (duty4_i),
      .half_o  (half),
      .slot_o  (slot)
   );

   lcd_com_bank #(.NUM_COMS(4)) u_coms (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .half_i      (half),
      .slot_i      (slot),
      .bias_half_i (bias_half_i),
      .psave_i     (quiet),
      .com_lvl_o   (com_all)
   );

   for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
      localparam int JP = (j < SKIP_AFTER) ? j : j + 1;
      logic [3:0] bits;
      logic       pmode;
      assign bits = duty4_i ? disp_i[4*j +: 4] : {1'b0, disp_i[3*JP +: 3]};
      if (j < NUM_PORTS) begin : g_pin
         logic port_q;
         assign pmode = (PW'(j) < port_cnt);
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) port_q <= 1'b0;
            else         port_q <= pmode & bits[0];
         end
         assign port_o[j] = port_q;
      end else begin : g_seg
         assign pmode = 1'b0;
      end
      lcd_seg_lane u_lane (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .half_i      (half),
         .slot_i      (slot),
         .bias_half_i (bias_half_i),
         .blank_i     (blank_i),
         .psave_i     (quiet),
         .port_mode_i (pmode),
         .bits_i      (bits),
         .lvl_o       (seg_lvl_o[2*j +: 2])
      );
   end

   lcd_seg_lane u_shared_seg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .half_i      (half),
      .slot_i      (slot),
      .bias_half_i (bias_half_i),
      .blank_i     (blank_i),
      .psave_i     (quiet),
      .port_mode_i (1'b0),
      .bits_i      ({1'b0, disp_i[3*SKIP_AFTER +: 3]}),
      .lvl_o       (seg40_lvl)
   );

   assign com_lvl_o    = com_all[5:0];
   assign shared_lvl_o = duty4_i ? com_all[7:6] : seg40_lvl;

   AST_PORTS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (port_sel_i == 2'b00) |=> (port_o == '0)); // R9

   AST_NO_V2_HALF_BIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bias_half_i && $past(bias_half_i)) |-> (com_lvl_o[1:0] != LV_V2 && shared_lvl_o != LV_V2)); // R10

endmodule

// File: tb/lcd_mux_sequencer_tb.sv
module lcd_mux_sequencer_tb;
   localparam int CLK_P = 10;
   localparam int NL    = 41;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          duty4 = 1'b0, bias_half = 1'b0, blank = 1'b0;
   logic [1:0]    psave = 2'b00, psel = 2'b00;
   logic [163:0]  disp = '0;
   logic [5:0]    com;
   logic [1:0]    shared;
   logic [81:0]   seg;
   logic [3:0]    port;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0;

   lcd_mux_sequencer u_dut (
      .clk_i(clk), .rst_ni(rst_n), .duty4_i(duty4), .bias_half_i(bias_half),
      .blank_i(blank), .psave_i(psave), .port_sel_i(psel), .disp_i(disp),
      .com_lvl_o(com), .shared_lvl_o(shared), .seg_lvl_o(seg), .port_o(port)
   );

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

   function automatic logic [1:0] m_com(bit sel, bit neg, bit bh);
      if (neg) return sel ? 2'b00 : 2'b10;
      return sel ? 2'b11 : (bh ? 2'b10 : 2'b01);
   endfunction

   function automatic logic [1:0] m_seg(bit on, bit neg, bit bh);
      if (!neg) return on ? 2'b00 : 2'b10;
      return on ? 2'b11 : (bh ? 2'b10 : 2'b01);
   endfunction

   function automatic logic [163:0] pat(int s);
      logic [163:0] v;
      for (int i = 0; i < 164; i++) v[i] = (((i * 7) + (s * 13) + ((i >> 2) * s)) % 5) < 2;
      return v;
   endfunction

   task automatic chk(string what, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual=%h expected=%h", what, cyc, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      logic [5:0]  ec;
      logic [1:0]  es;
      logic [81:0] eseg;
      logic [3:0]  ep;
      int d, slen, cnt, p, half, slot, idx;
      bit q;
      d    = duty4 ? 4 : 3;
      slen = 192 / d;
      cnt  = (psel == 2'b00) ? 0 : int'(psel) + 1;
      q    = (psave != 2'b00);
      ec = '0; es = '0; eseg = '0; ep = '0;
      if (cyc > 0) begin
         p    = (cyc - 1) % 384;
         half = p / 192;
         slot = (p % 192) / slen;
         for (int i = 0; i < 4; i++) ep[i] = (i < cnt) ? disp[d * i] : 1'b0;
         if (!q) begin
            for (int k = 0; k < 3; k++) ec[2*k +: 2] = m_com(slot == k, half[0], bias_half);
            if (duty4) es = m_com(slot == 3, half[0], bias_half);
            else       es = m_seg(disp[117 + slot] && !blank, half[0], bias_half);
            for (int j = 0; j < NL; j++) begin
               idx = duty4 ? (4 * j + slot) : (3 * ((j < 39) ? j : j + 1) + slot);
               eseg[2*j +: 2] = (j < cnt) ? 2'b00 : m_seg(disp[idx] && !blank, half[0], bias_half);
            end
         end
      end
      chk({tag, " commons"}, 128'(com), 128'(ec));
      chk({tag, " shared pin"}, 128'(shared), 128'(es));
      chk({tag, " segments"}, 128'(seg), 128'(eseg));
      chk({tag, " ports"}, 128'(port), 128'(ep));
   endtask

   task automatic wait_to(int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic do_reset(bit d4);
      @(negedge clk);
      rst_n = 1'b0;
      duty4 = d4;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_points(string tag, bit d4);
      int pts3[18] = '{1, 2, 63, 64, 65, 66, 128, 129, 130, 192, 193, 194, 257, 320, 384, 385, 386, 450};
      int pts4[18] = '{1, 2, 48, 49, 50, 96, 97, 144, 145, 146, 192, 193, 194, 241, 289, 337, 385, 386};
      for (int i = 0; i < 18; i++) begin
         wait_to(d4 ? pts4[i] : pts3[i]);
         check_all(tag);
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0; psel = 2'b11; disp = '1; bias_half = 1'b0;
      repeat (3) @(negedge clk);
      check_all("R1 reset");
      psel = 2'b00;
   endtask

   task automatic t_duty3;
      disp = pat(1); bias_half = 1'b0;
      do_reset(1'b0);
      run_points("R2 R3 R4 R5 three-common", 1'b0);
   endtask

   task automatic t_duty4;
      disp = pat(2); bias_half = 1'b0;
      do_reset(1'b1);
      run_points("R2 R3 R4 R6 four-common", 1'b1);
   endtask

   task automatic t_half_bias;
      disp = pat(3); bias_half = 1'b1;
      do_reset(1'b0);
      run_points("R10 half bias three-common", 1'b0);
      disp = pat(4);
      do_reset(1'b1);
      run_points("R10 half bias four-common", 1'b1);
      bias_half = 1'b0;
   endtask

   task automatic t_blank;
      disp = '1;
      do_reset(1'b1);
      wait_to(100);
      blank = 1'b1;
      wait_to(103); check_all("R7 blank");
      wait_to(200); check_all("R7 blank");
      wait_to(250); check_all("R7 blank");
      blank = 1'b0;
      wait_to(253); check_all("R7 unblank");
   endtask

   task automatic t_psave;
      disp = pat(5); psel = 2'b11;
      do_reset(1'b0);
      psave = 2'b01;
      wait_to(5);   check_all("R8 power save");
      wait_to(130); check_all("R8 power save");
      disp = ~disp;
      wait_to(133); check_all("R8 R9 power save ports");
      psave = 2'b11;
      wait_to(260); check_all("R8 power save");
      psave = 2'b00;
      wait_to(263); check_all("R8 resume");
      psel = 2'b00;
   endtask

   task automatic t_ports;
      disp = pat(6);
      for (int d = 0; d < 2; d++) begin
         do_reset(d[0]);
         for (int c = 0; c < 4; c++) begin
            psel = c[1:0];
            wait_to(cyc + 3);
            check_all("R9 port select");
         end
         disp = ~disp;
         wait_to(cyc + 3);
         check_all("R9 port data follow");
      end
      psel = 2'b00;
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      t_reset;
      t_duty3;
      t_duty4;
      t_half_bias;
      t_blank;
      t_psave;
      t_ports;
      done = 1;
      summary;
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R2: actual=running expected=finished");
         summary;
         $finish;
      end
   end

endmodule